// File: doc/BRIEF.md
# Ping-Pong Descriptor DMA Channel

This block moves bytes between a peripheral and memory using two descriptor slots that take turns. Each slot holds a start address, a byte count and a command word. One slot drives the transfer while software loads the other. When the running slot's count reaches zero, the channel retires that slot. If the other slot is armed, the channel moves straight to it without a gap. If it is not armed, the channel stops and raises an interrupt.

Software reaches the slots through a small 32-bit register window. A controller places many such channels side by side at a 0x20 stride. Each channel owns one memory request port. That port carries a single byte per request and uses a valid/ready handshake. In the write direction, bytes arrive from the peripheral on a valid/ready input stream and are written to memory. In the read direction, bytes are fetched from memory and sent out on a valid/ready output stream.

Back-pressure rules:
- Once a valid is raised, its payload is held unchanged until the matching ready is seen.
- The channel holds at most one byte between the two sides.
- It accepts a new byte only after the previous one has been passed on.

Top module: `pingpong_dma_chan`

## Requirements
- R1: Register window: slot s lives at offset 0x10*s, with address at +0x0, byte count at +0x4 and command at +0x8. The command word has arm at bit 0, direction at bit 1 (0 = peripheral to memory, 1 = memory to peripheral) and done at bit 8. It also shows two status bits: the index of the current slot at bit 16 and busy at bit 17. Every register reads zero after reset.
- R2: A write to a command register loads the arm and direction bits from the written data and clears done.
- R3: An idle channel starts on the current slot if that slot is armed. Otherwise, if the other slot is armed, it makes the other slot current and starts on it.
- R4: In the peripheral-to-memory direction, each input byte is written to memory at the slot address. Each accepted write then increments the address by one and decrements the count by one.
- R5: In the memory-to-peripheral direction, bytes are read from consecutive addresses and delivered on the output stream in address order. The count decrements once per delivered byte.
- R6: When the count reaches zero, the slot's arm bit clears, its done bit sets, and the other slot becomes current.
- R7: If the other slot is armed at completion, the channel continues on it with no interrupt.
- R8: If the other slot is not armed at completion, the channel goes idle and raises irq. irq stays high until any command register is written.
- R9: While busy, writes to the current slot are ignored. The other slot accepts writes freely.
- R10: A slot armed with a count of zero completes without issuing any memory request.
- R11: mem_req_valid and out_valid hold with a stable payload until ready is seen. While a byte waits for memory, in_ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset within the channel |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | AW | Byte address of the request |
| mem_req_wdata | output | 8 | Write data |
| mem_rsp_rdata | input | 8 | Read data, valid in the cycle a read is accepted |
| in_valid | input | 1 | Peripheral input byte valid |
| in_data | input | 8 | Peripheral input byte |
| in_ready | output | 1 | Channel accepts the input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Peripheral accepts the output byte |
| irq | output | 1 | Interrupt request: channel went idle after a completion |

## Verification
The hardest situation to reach from the ports is a hand-over from one slot to the next during a transfer, while software writes to both slots. To get there, the bench stalls the input stream, arms both slots, and then writes to the running slot and checks by readback that those writes are ignored. It then releases the stream and confirms that the interrupt rises exactly once, at the very end. Memory and peripheral stalls are set up with a ready pattern that alternates, and with a full memory stall that shows the single byte in flight.

// File: rtl/pingpong_dma_pkg.sv
package pingpong_dma_pkg;
  localparam int CMD_ARM_BIT  = 0;
  localparam int CMD_DIR_BIT  = 1;
  localparam int CMD_DONE_BIT = 8;
  localparam int CMD_CUR_BIT  = 16;
  localparam int CMD_BUSY_BIT = 17;
  localparam int NUM_SLOTS    = 2;
  localparam int REG_W        = 32;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pingpong_dma_slot.sv
module pingpong_dma_slot
  import pingpong_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             step_addr,
  input  logic             step_len,
  input  logic             finish,
  output logic [AW-1:0]    addr,
  output logic [LW-1:0]    len,
  output logic             arm,
  output logic             dir,
  output logic             done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      len  <= '0;
      arm  <= 1'b0;
      dir  <= 1'b0;
      done <= 1'b0;
    end else begin
      if (step_addr) addr <= addr + AW'(1);
      if (step_len)  len  <= len - LW'(1);
      if (wr_en) begin
        unique case (wr_sel)
          SEL_ADDR: addr <= wr_data[AW-1:0];
          SEL_LEN:  len  <= wr_data[LW-1:0];
          SEL_CMD: begin
            arm  <= wr_data[CMD_ARM_BIT];
            dir  <= wr_data[CMD_DIR_BIT];
            done <= 1'b0;
          end
          default: ;
        endcase
      end
      if (finish) begin
        arm  <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // R4
  len_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_len |-> (len != '0));
  // R6
  finish_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> arm);
endmodule

// File: rtl/pingpong_dma_mover.sv
module pingpong_dma_mover #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic [AW-1:0] cur_addr,
  input  logic [LW-1:0] cur_len,
  input  logic          cur_dir,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [7:0]    mem_req_wdata,
  input  logic [7:0]    mem_rsp_rdata,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [7:0]    out_data,
  input  logic          out_ready,
  output logic          step_addr,
  output logic          step_len,
  output logic          finish
);
  logic       hold_full;
  logic [7:0] hold_data;
  logic       len_nz, mem_acc, in_acc, out_acc;

  assign len_nz        = (cur_len != '0);
  assign in_ready      = busy && !cur_dir && !hold_full && len_nz;
  assign mem_req_valid = busy && (cur_dir ? (!hold_full && len_nz) : hold_full);
  assign mem_req_write = !cur_dir;
  assign mem_req_addr  = cur_addr;
  assign mem_req_wdata = hold_data;
  assign out_valid     = busy && cur_dir && hold_full;
  assign out_data      = hold_data;

  assign mem_acc   = mem_req_valid && mem_req_ready;
  assign in_acc    = in_valid && in_ready;
  assign out_acc   = out_valid && out_ready;
  assign step_addr = mem_acc;
  assign step_len  = cur_dir ? out_acc : mem_acc;
  assign finish    = busy && ((step_len && cur_len == LW'(1)) || (!len_nz && !hold_full));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else begin
      if (in_acc) begin
        hold_full <= 1'b1;
        hold_data <= in_data;
      end
      if (mem_acc && cur_dir) begin
        hold_full <= 1'b1;
        hold_data <= mem_rsp_rdata;
      end
      if ((mem_acc && !cur_dir) || out_acc) hold_full <= 1'b0;
    end
  end

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata)));
  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/pingpong_dma_chan.sv
module pingpong_dma_chan
  import pingpong_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [7:0]    mem_req_wdata,
  input  logic [7:0]    mem_rsp_rdata,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [7:0]    out_data,
  input  logic          out_ready,
  output logic          irq
);
  logic          busy_q, cur_q, irq_q;
  logic [AW-1:0] s_addr [NUM_SLOTS];
  logic [LW-1:0] s_len  [NUM_SLOTS];
  logic          s_arm  [NUM_SLOTS];
  logic          s_dir  [NUM_SLOTS];
  logic          s_done [NUM_SLOTS];
  logic          step_addr, step_len, finish;
  reg_sel_e      sel;
  logic          slot_idx, other, cmd_wr;

  assign sel      = reg_sel_e'(reg_addr[3:2]);
  assign slot_idx = reg_addr[4];
  assign other    = ~cur_q;
  assign cmd_wr   = reg_we && (sel == SEL_CMD);
  assign irq      = irq_q;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic mine;
    assign mine = (cur_q == 1'(g));
    pingpong_dma_slot #(.AW(AW), .LW(LW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_we && (slot_idx == 1'(g)) && !(busy_q && mine)),
      .wr_sel    (sel),
      .wr_data   (reg_wdata),
      .step_addr (step_addr && busy_q && mine),
      .step_len  (step_len && busy_q && mine),
      .finish    (finish && mine),
      .addr      (s_addr[g]),
      .len       (s_len[g]),
      .arm       (s_arm[g]),
      .dir       (s_dir[g]),
      .done      (s_done[g])
    );
  end

  pingpong_dma_mover #(.AW(AW), .LW(LW)) u_mover (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy_q),
    .cur_addr      (s_addr[cur_q]),
    .cur_len       (s_len[cur_q]),
    .cur_dir       (s_dir[cur_q]),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_rdata (mem_rsp_rdata),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_data      (out_data),
    .out_ready     (out_ready),
    .step_addr     (step_addr),
    .step_len      (step_len),
    .finish        (finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (cmd_wr) irq_q <= 1'b0;
      if (finish) begin
        cur_q <= other;
        if (!s_arm[other]) begin
          busy_q <= 1'b0;
          irq_q  <= 1'b1;
        end
      end else if (!busy_q) begin
        if (s_arm[cur_q]) begin
          busy_q <= 1'b1;
        end else if (s_arm[other]) begin
          cur_q  <= other;
          busy_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_ADDR: reg_rdata[AW-1:0] = s_addr[slot_idx];
      SEL_LEN:  reg_rdata[LW-1:0] = s_len[slot_idx];
      SEL_CMD: begin
        reg_rdata[CMD_ARM_BIT]  = s_arm[slot_idx];
        reg_rdata[CMD_DIR_BIT]  = s_dir[slot_idx];
        reg_rdata[CMD_DONE_BIT] = s_done[slot_idx];
        reg_rdata[CMD_CUR_BIT]  = cur_q;
        reg_rdata[CMD_BUSY_BIT] = busy_q;
      end
      default: ;
    endcase
  end

  // R3
  start_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> s_arm[cur_q]);
  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> !busy_q);
  // R10
  req_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready || mem_req_valid || out_valid) |-> busy_q);
endmodule

// File: tb/pingpong_dma_chan_test.sv
`timescale 1ns/1ps
module pingpong_dma_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr;
  logic [7:0]  mem_req_wdata, mem_rsp_rdata;
  logic        in_valid, in_ready, out_valid, out_ready, irq;
  logic [7:0]  in_data, out_data;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  mem [256];
  logic [7:0]  src_idx = '0;
  logic        src_en = 1'b0;
  logic        sink_en = 1'b0;
  logic [7:0]  sink_buf [64];
  int          sink_cnt = 0;
  logic [1:0]  mrdy_mode = 2'd0;
  logic [7:0]  cyc = '0;
  logic        irq_d = 1'b0;
  int          irq_rises = 0;
  int          mem_acc_cnt = 0;

  always #2 clk = ~clk;

  pingpong_dma_chan uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_rdata(mem_rsp_rdata),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .irq(irq)
  );

  function automatic logic [7:0] srcf(input logic [7:0] i);
    return i ^ 8'h5A;
  endfunction
  function automatic logic [7:0] memf(input int i);
    return 8'(i * 7 + 3);
  endfunction

  assign in_valid      = src_en;
  assign in_data       = srcf(src_idx);
  assign out_ready     = sink_en && cyc[0];
  assign mem_req_ready = (mrdy_mode == 2'd0) ? 1'b1 : (mrdy_mode == 2'd1) ? cyc[1] : 1'b0;
  assign mem_rsp_rdata = mem[mem_req_addr[7:0]];

  initial for (int i = 0; i < 256; i++) mem[i] = memf(i);

  always @(posedge clk) begin
    cyc   <= cyc + 8'd1;
    irq_d <= irq;
    if (irq && !irq_d) irq_rises <= irq_rises + 1;
    if (in_valid && in_ready) src_idx <= src_idx + 8'd1;
    if (mem_req_valid && mem_req_ready) begin
      mem_acc_cnt <= mem_acc_cnt + 1;
      if (mem_req_write) mem[mem_req_addr[7:0]] <= mem_req_wdata;
    end
    if (out_valid && out_ready) begin
      sink_buf[sink_cnt[5:0]] <= out_data;
      sink_cnt <= sink_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk(req, 32'(irq), 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_rd(5'h08, d); chk("R1 cmd0 reset", d, 32'h0);
    reg_rd(5'h18, d); chk("R1 cmd1 reset", d, 32'h0);
    reg_rd(5'h00, d); chk("R1 addr0 reset", d, 32'h0);
    reg_rd(5'h14, d); chk("R1 len1 reset", d, 32'h0);
    chk("R1 irq reset", 32'(irq), 32'd0);
    chk("R1 streams idle", {29'd0, in_ready, mem_req_valid, out_valid}, 32'd0);
  endtask

  task automatic t_single_write();
    logic [31:0] d;
    logic [7:0] st;
    st = src_idx;
    reg_wr(5'h00, 32'h10);
    reg_wr(5'h04, 32'd4);
    reg_wr(5'h08, 32'h1);
    src_en = 1'b1;
    wait_irq("R8 irq after single slot");
    src_en = 1'b0;
    for (int i = 0; i < 4; i++) chk("R4 written byte", 32'(mem[8'h10 + i]), 32'(srcf(st + 8'(i))));
    reg_rd(5'h00, d); chk("R4 address advanced", d, 32'h14);
    reg_rd(5'h04, d); chk("R4 count zero", d, 32'h0);
    reg_rd(5'h08, d); chk("R6 done set, arm clear, slot flipped", d, 32'h10100);
    reg_wr(5'h08, 32'h0);
    chk("R8 irq cleared by cmd write", 32'(irq), 32'd0);
    reg_rd(5'h08, d); chk("R2 done cleared by cmd write", d, 32'h10000);
  endtask

  task automatic t_idle_other();
    logic [31:0] d;
    logic [7:0] st;
    st = src_idx;
    reg_wr(5'h00, 32'h20);
    reg_wr(5'h04, 32'd2);
    reg_wr(5'h08, 32'h1);
    @(negedge clk);
    reg_rd(5'h08, d); chk("R3 idle start on other armed slot", d, 32'h20001);
    src_en = 1'b1;
    wait_irq("R3 transfer finished");
    src_en = 1'b0;
    for (int i = 0; i < 2; i++) chk("R3 data", 32'(mem[8'h20 + i]), 32'(srcf(st + 8'(i))));
    reg_wr(5'h18, 32'h0);
  endtask

  task automatic t_pingpong();
    logic [31:0] d;
    logic [7:0] st;
    int r0;
    st = src_idx;
    reg_wr(5'h10, 32'h40); reg_wr(5'h14, 32'd3);
    reg_wr(5'h00, 32'h60); reg_wr(5'h04, 32'd2);
    reg_wr(5'h18, 32'h1);
    @(negedge clk);
    reg_wr(5'h08, 32'h1);
    reg_wr(5'h10, 32'hFF);
    reg_wr(5'h14, 32'd9);
    reg_rd(5'h10, d); chk("R9 running slot address kept", d, 32'h40);
    reg_rd(5'h14, d); chk("R9 running slot count kept", d, 32'd3);
    reg_rd(5'h08, d); chk("R9 idle slot armed while busy", d, 32'h30001);
    r0 = irq_rises;
    src_en = 1'b1;
    wait_irq("R7 chain finished");
    src_en = 1'b0;
    @(negedge clk);
    chk("R7 single interrupt for chain", 32'(irq_rises - r0), 32'd1);
    for (int i = 0; i < 3; i++) chk("R7 first slot data", 32'(mem[8'h40 + i]), 32'(srcf(st + 8'(i))));
    for (int i = 0; i < 2; i++) chk("R7 second slot data", 32'(mem[8'h60 + i]), 32'(srcf(st + 8'(3 + i))));
    reg_rd(5'h18, d); chk("R6 first slot retired", d, 32'h10100);
    reg_rd(5'h08, d); chk("R6 second slot retired", d, 32'h10100);
    reg_wr(5'h08, 32'h0);
  endtask

  task automatic t_read_dir();
    logic [31:0] d;
    int s0;
    s0 = sink_cnt;
    mrdy_mode = 2'd1;
    sink_en = 1'b1;
    reg_wr(5'h10, 32'h80); reg_wr(5'h14, 32'd6);
    reg_wr(5'h18, 32'h3);
    wait_irq("R5 read transfer finished");
    @(negedge clk);
    chk("R5 delivered count", 32'(sink_cnt - s0), 32'd6);
    for (int i = 0; i < 6; i++) chk("R5 delivered byte", 32'(sink_buf[6'(s0 + i)]), 32'(memf(8'h80 + i)));
    reg_rd(5'h10, d); chk("R5 address advanced", d, 32'h86);
    reg_rd(5'h18, d); chk("R5 slot retired", d, 32'h102);
    sink_en = 1'b0;
    mrdy_mode = 2'd0;
    reg_wr(5'h18, 32'h0);
  endtask

  task automatic t_write_bp();
    logic [7:0] st;
    st = src_idx;
    mrdy_mode = 2'd2;
    reg_wr(5'h00, 32'hA0); reg_wr(5'h04, 32'd5);
    reg_wr(5'h08, 32'h1);
    src_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 request held under stall", {31'd0, mem_req_valid}, 32'd1);
    chk("R11 address held under stall", mem_req_addr, 32'hA0);
    chk("R11 input blocked while byte waits", {31'd0, in_ready}, 32'd0);
    mrdy_mode = 2'd1;
    wait_irq("R11 stalled write finished");
    src_en = 1'b0;
    mrdy_mode = 2'd0;
    for (int i = 0; i < 5; i++) chk("R11 data after stall", 32'(mem[8'hA0 + i]), 32'(srcf(st + 8'(i))));
    reg_wr(5'h08, 32'h0);
  endtask

  task automatic t_zero_len();
    logic [31:0] d;
    int m0;
    m0 = mem_acc_cnt;
    reg_wr(5'h10, 32'hC0); reg_wr(5'h14, 32'd0);
    reg_wr(5'h18, 32'h1);
    wait_irq("R10 zero count completes");
    chk("R10 no memory request", 32'(mem_acc_cnt - m0), 32'd0);
    reg_rd(5'h18, d); chk("R10 slot retired", d, 32'h100);
    reg_rd(5'h10, d); chk("R10 address untouched", d, 32'hC0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single_write();
    t_idle_other();
    t_pingpong();
    t_read_dir();
    t_write_bp();
    t_zero_len();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule